// File: doc/BRIEF.md
# Encoder Feed Sequencer

This block paces an intra video encoder frame by frame and band by band, where a band is 16 picture lines. A main controller runs on the base clock. It raises the encoder's frame-start, band-start and frame-close strobes. Two channel controllers run on a phase-aligned clock at twice the base rate. One serves luma and one serves chroma. Each grants its reorder stream a read enable for the current band. It then waits for that stream's band-complete flag.

A band starts only when all three controllers agree. The frame buffer must report data, the encoder must report that it has drained the previous band, and both channel controllers must be armed. Both channels must also have reported completion before the next band may start. This keeps luma and chroma delivery in lockstep.

The fast controllers look at the main controller only on the fast edge that coincides with a base edge. These looks cover whether it is encoding, whether it is preparing a frame, and whether the current band is the last. The block uses one active-low asynchronous reset for both clocks. That reset is released shortly after a base-clock rising edge, before the next fast rising edge.

Top module: `encoder_feed_seq`

## Requirements
- R1: While reset is held, all strobes and both enables are low and the band index reads 0.
- R2: When the controller is preparing a frame and the buffer reports data, `new_frame` pulses for exactly one base cycle, and the band index reads 0 in that same cycle.
- R3: `new_line` is a single base-cycle pulse. It never fires while `band_done` is low or `buf_avail` is low, and both enables stay low until it has fired.
- R4: `y_en` and `c_en` rise on the same fast clock edge at the start of every band.
- R5: A read-complete flag that arrives while its channel enable is low has no effect: the following band still keeps its enable high until a fresh flag arrives.
- R6: Each enable drops on its own channel's read-complete flag. The next band does not start while the other channel has not yet completed.
- R7: The band index advances by one after each band that is not the last of the frame.
- R8: After the last band, `frame_align` pulses once and no further `new_line` fires. Both enables are low from that pulse onward, and the band index then reads `cfg_bands` minus 1.
- R9: After `frame_align`, no new frame starts until `frame_done` is seen, even if the buffer reports data.
- R10: A `cfg_bands` value of 0 behaves as a single band per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| clk2x | input | 1 | Phase-aligned clock at twice the base rate |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| cfg_bands | input | BAND_W | Bands per frame, held stable during a frame |
| buf_avail | input | 1 | Buffered pixel data is present (base domain) |
| band_done | input | 1 | Encoder has drained the previous band (base domain) |
| frame_done | input | 1 | Encoder confirms the whole frame is encoded (base domain) |
| y_rd_done | input | 1 | Luma reorder stream finished its band (fast domain pulse) |
| c_rd_done | input | 1 | Chroma reorder stream finished its band (fast domain pulse) |
| new_frame | output | 1 | Frame-start strobe to the encoder |
| new_line | output | 1 | Band-start strobe to the encoder |
| frame_align | output | 1 | End-of-frame strobe to the encoder |
| y_en | output | 1 | Luma reorder read enable (fast domain) |
| c_en | output | 1 | Chroma reorder read enable (fast domain) |
| cur_band | output | BAND_W | Index of the band in progress |

## Verification
Two events can land on the same fast edge. Both channels can report completion together. On the last band, the luma controller can also enter its end-of-frame state on the very edge where chroma reports. Table rows with equal luma and chroma delays provoke both coincidences, and rows with unequal delays provoke the staggered case. Each run is judged on the count of band strobes, the single close strobe, the band index seen at that strobe, and the absence of any enable that rises alone.

// File: rtl/encoder_feed_seq.sv
module encoder_feed_seq #(
  parameter int BAND_W = 8
) (
  input  logic              clk,
  input  logic              clk2x,
  input  logic              rst_n,
  input  logic [BAND_W-1:0] cfg_bands,
  input  logic              buf_avail,
  input  logic              band_done,
  input  logic              frame_done,
  input  logic              y_rd_done,
  input  logic              c_rd_done,
  output logic              new_frame,
  output logic              new_line,
  output logic              frame_align,
  output logic              y_en,
  output logic              c_en,
  output logic [BAND_W-1:0] cur_band
);

  localparam int CW = BAND_W + 1;

  typedef enum logic [2:0] {M_RST, M_PFRM, M_PLIN, M_ENC, M_ALN} main_t;
  typedef enum logic [1:0] {C_RST, C_WAIT, C_ABLE, C_EOF} chan_t;

  main_t m_st, m_nx;
  chan_t y_st, y_nx, c_st, c_nx;

  logic [BAND_W-1:0] band_q;
  logic tog, tog_q;
  logic enc_s, pfrm_s, last_s;

  wire last_band = ({1'b0, band_q} + CW'(1)) >= {1'b0, cfg_bands};
  wire aligned   = (tog == tog_q);
  wire y_wait    = (y_st == C_WAIT);
  wire c_wait    = (c_st == C_WAIT);
  wire both_able = (y_st == C_ABLE) && (c_st == C_ABLE);

  always_comb begin
    m_nx = m_st;
    case (m_st)
      M_RST:  m_nx = M_PFRM;
      M_PFRM: if (buf_avail) m_nx = M_PLIN;
      M_PLIN: if (band_done && buf_avail && both_able) m_nx = M_ENC;
      M_ENC:  if (c_wait && y_st == C_EOF) m_nx = M_ALN;
              else if (c_wait && y_wait)   m_nx = M_PLIN;
      M_ALN:  if (frame_done) m_nx = M_PFRM;
      default: m_nx = M_RST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st        <= M_RST;
      tog         <= 1'b0;
      band_q      <= '0;
      new_frame   <= 1'b0;
      new_line    <= 1'b0;
      frame_align <= 1'b0;
    end else begin
      m_st        <= m_nx;
      tog         <= ~tog;
      new_frame   <= (m_st == M_PFRM) && (m_nx == M_PLIN);
      new_line    <= (m_st == M_PLIN) && (m_nx == M_ENC);
      frame_align <= (m_st == M_ENC)  && (m_nx == M_ALN);
      if (m_st == M_PFRM && m_nx == M_PLIN)
        band_q <= '0;
      else if (m_st == M_ENC && m_nx == M_PLIN)
        band_q <= band_q + 1'b1;
    end
  end

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      tog_q  <= 1'b1;
      enc_s  <= 1'b0;
      pfrm_s <= 1'b0;
      last_s <= 1'b0;
    end else begin
      tog_q <= tog;
      if (aligned) begin
        enc_s  <= (m_st == M_ENC);
        pfrm_s <= (m_st == M_PFRM);
        last_s <= last_band;
      end
    end
  end

  always_comb begin
    y_nx = y_st;
    case (y_st)
      C_RST:  y_nx = C_WAIT;
      C_WAIT: if (c_wait && !enc_s) y_nx = C_ABLE;
      C_ABLE: if (y_rd_done && enc_s) y_nx = last_s ? C_EOF : C_WAIT;
      C_EOF:  if (pfrm_s) y_nx = C_WAIT;
      default: y_nx = C_RST;
    endcase
  end

  always_comb begin
    c_nx = c_st;
    case (c_st)
      C_RST:  c_nx = C_WAIT;
      C_WAIT: if (y_wait && !enc_s) c_nx = C_ABLE;
      C_ABLE: if (c_rd_done && enc_s) c_nx = C_WAIT;
      default: c_nx = C_RST;
    endcase
  end

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      y_st <= C_RST;
      c_st <= C_RST;
    end else begin
      y_st <= y_nx;
      c_st <= c_nx;
    end
  end

  assign y_en     = (y_st == C_ABLE) && enc_s;
  assign c_en     = (c_st == C_ABLE) && enc_s;
  assign cur_band = band_q;

endmodule

// File: rtl/encoder_feed_seq_chk.sv
module encoder_feed_seq_chk #(
  parameter int BAND_W = 8
) (
  input logic              clk,
  input logic              clk2x,
  input logic              rst_n,
  input logic              new_frame,
  input logic              new_line,
  input logic              frame_align,
  input logic              y_en,
  input logic              c_en,
  input logic [BAND_W-1:0] cur_band
);

  AST_NL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    new_line |=> !new_line); // R3

  AST_NF_BAND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    new_frame |-> cur_band == '0); // R2

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({new_frame, new_line, frame_align})); // R8

  AST_ALIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_align |-> (!y_en && !c_en)); // R8

  AST_BAND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_band != $past(cur_band)) |-> (cur_band == $past(cur_band) + 1'b1 || cur_band == '0)); // R7

  AST_EN_LOCKSTEP: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(y_en) |-> $rose(c_en)); // R4

endmodule

bind encoder_feed_seq encoder_feed_seq_chk #(.BAND_W(BAND_W)) u_chk (
  .clk(clk), .clk2x(clk2x), .rst_n(rst_n),
  .new_frame(new_frame), .new_line(new_line), .frame_align(frame_align),
  .y_en(y_en), .c_en(c_en), .cur_band(cur_band)
);

// File: tb/encoder_feed_seq_tb.sv
`timescale 1ns/1ps
module encoder_feed_seq_tb;

  logic clk = 1'b0, clk2x = 1'b0, rst_n = 1'b0;
  logic [7:0] cfg_bands = 8'd1;
  logic buf_avail = 1'b0, band_done = 1'b0, frame_done = 1'b0;
  logic y_rd_done = 1'b0, c_rd_done = 1'b0;
  logic new_frame, new_line, frame_align, y_en, c_en;
  logic [7:0] cur_band;

  int n_chk = 0, n_fail = 0;
  int nf_cnt = 0, nl_cnt = 0, al_cnt = 0, mism = 0;
  logic py = 1'b0, pc = 1'b0;

  // {bands, luma delay, chroma delay, close delay, expected bands, expected last index}
  localparam logic [47:0] VEC [6] = '{
    {8'd1, 8'd0, 8'd0, 8'd0, 8'd1, 8'd0},
    {8'd3, 8'd2, 8'd5, 8'd1, 8'd3, 8'd2},
    {8'd4, 8'd7, 8'd1, 8'd3, 8'd4, 8'd3},
    {8'd0, 8'd1, 8'd1, 8'd0, 8'd1, 8'd0},
    {8'd2, 8'd0, 8'd9, 8'd2, 8'd2, 8'd1},
    {8'd5, 8'd3, 8'd3, 8'd0, 8'd5, 8'd4}
  };

  encoder_feed_seq #(.BAND_W(8)) u_dut (
    .clk(clk), .clk2x(clk2x), .rst_n(rst_n), .cfg_bands(cfg_bands),
    .buf_avail(buf_avail), .band_done(band_done), .frame_done(frame_done),
    .y_rd_done(y_rd_done), .c_rd_done(c_rd_done),
    .new_frame(new_frame), .new_line(new_line), .frame_align(frame_align),
    .y_en(y_en), .c_en(c_en), .cur_band(cur_band)
  );

  initial forever begin
    clk = 1'b1; clk2x = 1'b1; #1.25;
    clk2x = 1'b0; #1.25;
    clk = 1'b0; clk2x = 1'b1; #1.25;
    clk2x = 1'b0; #1.25;
  end

  always @(negedge clk) begin
    if (new_frame)   nf_cnt++;
    if (new_line)    nl_cnt++;
    if (frame_align) al_cnt++;
  end

  always @(negedge clk2x) begin
    if ((y_en && !py) != (c_en && !pc)) mism++;
    py <= y_en;
    pc <= c_en;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic y_serve(input int d);
    while (!y_en) @(negedge clk2x);
    repeat (d) @(negedge clk2x);
    y_rd_done = 1'b1; @(negedge clk2x); y_rd_done = 1'b0;
  endtask

  task automatic c_serve(input int d);
    while (!c_en) @(negedge clk2x);
    repeat (d) @(negedge clk2x);
    c_rd_done = 1'b1; @(negedge clk2x); c_rd_done = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    int nf0, nl0, al0, mm0;
    @(negedge clk); @(negedge clk);
    chk("R1 strobes in reset", {29'd0, new_frame, new_line, frame_align}, 0);
    chk("R1 enables in reset", {30'd0, y_en, c_en}, 0);
    chk("R1 band in reset", cur_band, 0);
    @(posedge clk); #0.5 rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      int nb, yd, cd, fd, eb, el;
      nb = VEC[i][47:40]; yd = VEC[i][39:32]; cd = VEC[i][31:24];
      fd = VEC[i][23:16]; eb = VEC[i][15:8];  el = VEC[i][7:0];
      nf0 = nf_cnt; nl0 = nl_cnt; al0 = al_cnt; mm0 = mism;
      cfg_bands = 8'(nb);
      band_done = 1'b1;
      buf_avail = 1'b1;
      fork
        begin for (int b = 0; b < eb; b++) y_serve(yd); end
        begin for (int b = 0; b < eb; b++) c_serve(cd); end
      join
      while (al_cnt == al0) @(negedge clk);
      chk("R8 last band index at close", cur_band, el);
      buf_avail = 1'b0;
      repeat (fd) @(negedge clk);
      frame_done = 1'b1; @(negedge clk); frame_done = 1'b0;
      repeat (4) @(negedge clk);
      chk("R2 one frame start", nf_cnt - nf0, 1);
      chk("R7 R10 band starts", nl_cnt - nl0, eb);
      chk("R8 one close strobe", al_cnt - al0, 1);
      chk("R4 lone enable rise", mism - mm0, 0);
    end

    // directed: held encoder, stray flags, staggered channels, held close
    nf0 = nf_cnt; nl0 = nl_cnt; al0 = al_cnt;
    cfg_bands = 8'd2;
    band_done = 1'b0;
    buf_avail = 1'b1;
    repeat (12) @(negedge clk);
    chk("R2 frame start while encoder busy", nf_cnt - nf0, 1);
    chk("R3 no band start while band_done low", nl_cnt - nl0, 0);
    chk("R3 luma enable before band start", y_en, 0);
    @(negedge clk2x);
    y_rd_done = 1'b1; c_rd_done = 1'b1;
    @(negedge clk2x);
    y_rd_done = 1'b0; c_rd_done = 1'b0;
    repeat (2) @(negedge clk);
    band_done = 1'b1;
    while (!y_en) @(negedge clk2x);
    repeat (10) @(negedge clk);
    chk("R5 luma enable kept after stray flag", y_en, 1);
    chk("R5 chroma enable kept after stray flag", c_en, 1);
    chk("R3 single band start", nl_cnt - nl0, 1);
    y_serve(0);
    repeat (10) @(negedge clk);
    chk("R6 luma enable dropped", y_en, 0);
    chk("R6 chroma enable held", c_en, 1);
    chk("R6 no band start with chroma pending", nl_cnt - nl0, 1);
    chk("R6 band index held", cur_band, 0);
    c_serve(0);
    repeat (8) @(negedge clk);
    chk("R7 second band started", nl_cnt - nl0, 2);
    chk("R7 band index advanced", cur_band, 1);
    fork
      y_serve(1);
      c_serve(1);
    join
    while (al_cnt == al0) @(negedge clk);
    repeat (8) @(negedge clk);
    chk("R9 no frame start before frame_done", nf_cnt - nf0, 1);
    chk("R8 luma enable low after close", y_en, 0);
    frame_done = 1'b1; @(negedge clk); frame_done = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 frame start after frame_done", nf_cnt - nf0, 2);
    chk("R2 band index cleared", cur_band, 0);
    buf_avail = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule